// File: doc/BRIEF.md
# Packet Buffer Block Allocator with Per-Port Descriptor Rings

This block keeps track of which fixed-size blocks of a shared packet memory are in use, and it queues finished packets to the output ports of a small switch. When a packet begins to arrive, the receive side asks for a block. In the same cycle the block returns the free block with the lowest index and marks it used. When the packet ends without error, the block writes a descriptor into the circular ring of the target port. The descriptor holds the byte count and the block index.

Every output port sees a pending flag while its ring holds descriptors. The oldest descriptor of the selected port is presented to the transmitter. When the transmitter reports completion, that ring's read side advances and the block goes back to the free pool. A block therefore stays claimed from the start of reception until its transmission is finished. A packet that ends with an error, or that targets a full ring, is discarded and its block is freed at once.

Top module: `bufq_top`

## Requirements
- R1: After reset all blocks are free and no port reports pending; with no request, `no_buf` is 0.
- R2: While `rx_start` is high and a block is free, `rx_grant` is 1 in the same cycle and `rx_blk` is the lowest-index free block. That block counts as used from the next cycle on.
- R3: When no block is free (counting same-cycle releases), `no_buf` is 1 and `rx_grant` is 0. No block is claimed, and the request may be held until a block frees.
- R4: A block released in a cycle is already available to an allocation in that same cycle; release takes effect before allocation.
- R5: An `rx_end` with `rx_ok`=1 to a ring that is not full stores {`rx_bcnt`, `rx_end_blk`} at the ring tail. From the next cycle, `tx_pend[rx_port]` is 1.
- R6: A port's pending bit is 1 exactly while its ring holds descriptors. `tx_head_bcnt`/`tx_head_blk` show the oldest stored descriptor of port `tx_port`, and descriptors leave in arrival order.
- R7: `tx_done` on a pending port removes its oldest descriptor and frees that descriptor's block.
- R8: An `rx_end` with `rx_ok`=0 stores nothing and frees `rx_end_blk`.
- R9: A ring holds at most RING_DEPTH descriptors. An error-free `rx_end` to a full ring is dropped and its block is freed, even if that port's `tx_done` falls in the same cycle.
- R10: `tx_done` on a port with no pending descriptor has no effect on any ring or on the block pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Request a block for an arriving packet |
| rx_grant | output | 1 | Block granted this cycle |
| rx_blk | output | $clog2(NUM_BLOCKS) | Granted block index |
| no_buf | output | 1 | No block is free this cycle |
| rx_end | input | 1 | Packet reception finished |
| rx_ok | input | 1 | Finished packet had no error |
| rx_port | input | $clog2(NUM_PORTS) | Target output port of finished packet |
| rx_bcnt | input | BCNT_W | Byte count of finished packet |
| rx_end_blk | input | $clog2(NUM_BLOCKS) | Block holding the finished packet |
| tx_pend | output | NUM_PORTS | Per-port descriptor pending flags |
| tx_port | input | $clog2(NUM_PORTS) | Port whose head descriptor is shown and retired |
| tx_head_bcnt | output | BCNT_W | Byte count of head descriptor of `tx_port` |
| tx_head_blk | output | $clog2(NUM_BLOCKS) | Block of head descriptor of `tx_port` |
| tx_done | input | 1 | Transmission of head descriptor of `tx_port` finished |

## Verification
A block release can fall in the same cycle as an allocation request. The release comes from a completed transmission or from a dropped or faulty packet. The bench provokes this by first claiming every block, so that `no_buf` is high. It then raises `tx_done` on a port holding a descriptor while `rx_start` is high, and it requires the grant to return exactly the block being released. The same collision runs throughout the random phase, and also a store to a full ring in the same cycle as that ring's retirement. Both are judged against a bench model that frees blocks before it picks the lowest free one.

// File: rtl/bufq_pkg.sv
package bufq_pkg;
  typedef enum logic [1:0] {
    END_IDLE  = 2'd0,
    END_STORE = 2'd1,
    END_DROP  = 2'd2
  } end_act_e;
endpackage

// File: rtl/bufq_lowfree.sv
module bufq_lowfree #(
  parameter int W = 16,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

  always_comb begin
    if (found) a_r2_pick_free: assert (vec[idx]);
  end
endmodule

// File: rtl/bufq_bitmap.sv
module bufq_bitmap #(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc_req,
  input  logic [NUM_BLOCKS-1:0] rel_mask,
  output logic                  grant,
  output logic [BLK_W-1:0]      grant_blk,
  output logic                  no_buf
);
  logic [NUM_BLOCKS-1:0] used_q, used_d, free_vec, claim;
  logic                  any_free;

  // release is applied before the search
  assign free_vec = ~used_q | rel_mask;

  bufq_lowfree #(.W(NUM_BLOCKS)) u_enc (
    .vec   (free_vec),
    .found (any_free),
    .idx   (grant_blk)
  );

  assign grant  = alloc_req & any_free;
  assign no_buf = ~any_free;

  always_comb begin
    claim = '0;
    if (grant) claim[grant_blk] = 1'b1;
    used_d = (used_q & ~rel_mask) | claim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_d;
  end

  a_r2_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> used_q[$past(grant_blk)]);
  a_r7_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rel_mask) && !grant) |=> ((used_q & $past(rel_mask)) == '0));
  a_r3_nobuf_full: assert property (@(posedge clk) disable iff (!rst_n)
    no_buf |-> (&used_q));
endmodule

// File: rtl/bufq_ring.sv
module bufq_ring #(
  parameter int DEPTH  = 4,
  parameter int BCNT_W = 11,
  parameter int BLK_W  = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BCNT_W-1:0] wr_bcnt,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic              rd_en,
  output logic              pend,
  output logic              full,
  output logic [BCNT_W-1:0] head_bcnt,
  output logic [BLK_W-1:0]  head_blk
);
  logic [PW:0]       wptr_q, wptr_d, rptr_q, rptr_d;
  logic [BCNT_W-1:0] mem_bcnt [DEPTH];
  logic [BLK_W-1:0]  mem_blk  [DEPTH];

  assign pend = (wptr_q != rptr_q);
  assign full = (wptr_q[PW] != rptr_q[PW]) && (wptr_q[PW-1:0] == rptr_q[PW-1:0]);
  assign head_bcnt = mem_bcnt[rptr_q[PW-1:0]];
  assign head_blk  = mem_blk[rptr_q[PW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (wr_en) wptr_d = wptr_q + 1'b1;
    if (rd_en) rptr_d = rptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_bcnt[wptr_q[PW-1:0]] <= wr_bcnt;
      mem_blk[wptr_q[PW-1:0]]  <= wr_blk;
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> pend);
  a_r5_pend_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pend);
  a_r6_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rd_en) |=> ($stable(head_bcnt) && $stable(head_blk)));
endmodule

// File: rtl/bufq_top.sv
module bufq_top #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int RING_DEPTH = 4,
  parameter int BCNT_W     = 11,
  localparam int BLK_W  = $clog2(NUM_BLOCKS),
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_start,
  output logic                 rx_grant,
  output logic [BLK_W-1:0]     rx_blk,
  output logic                 no_buf,
  input  logic                 rx_end,
  input  logic                 rx_ok,
  input  logic [PORT_W-1:0]    rx_port,
  input  logic [BCNT_W-1:0]    rx_bcnt,
  input  logic [BLK_W-1:0]     rx_end_blk,
  output logic [NUM_PORTS-1:0] tx_pend,
  input  logic [PORT_W-1:0]    tx_port,
  output logic [BCNT_W-1:0]    tx_head_bcnt,
  output logic [BLK_W-1:0]     tx_head_blk,
  input  logic                 tx_done
);
  import bufq_pkg::*;

  logic [NUM_PORTS-1:0]  ring_full, ring_wr, ring_rd;
  logic [BCNT_W-1:0]     head_bcnt [NUM_PORTS];
  logic [BLK_W-1:0]      head_blk  [NUM_PORTS];
  logic [NUM_BLOCKS-1:0] rel_mask;
  logic                  tx_retire;
  end_act_e              end_act;

  always_comb begin
    end_act = END_IDLE;
    if (rx_end) begin
      if (rx_ok && !ring_full[rx_port]) end_act = END_STORE;
      else                              end_act = END_DROP;
    end
  end

  assign tx_retire = tx_done & tx_pend[tx_port];

  always_comb begin
    ring_wr = '0;
    ring_rd = '0;
    if (end_act == END_STORE) ring_wr[rx_port] = 1'b1;
    if (tx_retire)            ring_rd[tx_port] = 1'b1;
  end

  always_comb begin
    rel_mask = '0;
    if (end_act == END_DROP) rel_mask[rx_end_blk] = 1'b1;
    if (tx_retire)           rel_mask[head_blk[tx_port]] = 1'b1;
  end

  assign tx_head_bcnt = head_bcnt[tx_port];
  assign tx_head_blk  = head_blk[tx_port];

  bufq_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_bitmap (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (rx_start),
    .rel_mask  (rel_mask),
    .grant     (rx_grant),
    .grant_blk (rx_blk),
    .no_buf    (no_buf)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_ring
    bufq_ring #(.DEPTH(RING_DEPTH), .BCNT_W(BCNT_W), .BLK_W(BLK_W)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ring_wr[p]),
      .wr_bcnt   (rx_bcnt),
      .wr_blk    (rx_end_blk),
      .rd_en     (ring_rd[p]),
      .pend      (tx_pend[p]),
      .full      (ring_full[p]),
      .head_bcnt (head_bcnt[p]),
      .head_blk  (head_blk[p])
    );
  end

  a_r8_error_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_end && !rx_ok) |=> $stable(tx_pend) || ($past(tx_retire) && !$past(ring_wr)));
  a_r10_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_pend[tx_port] && !rx_end) |-> (rel_mask == '0));
endmodule

// File: tb/bufq_top_bench.sv
module bufq_top_bench;
  localparam int NP = 4;
  localparam int NB = 16;
  localparam int D  = 4;
  localparam int BW = 11;
  localparam int KW = $clog2(NB);
  localparam int PW = $clog2(NP);

  logic          clk, rst_n;
  logic          rx_start, rx_grant, no_buf, rx_end, rx_ok, tx_done;
  logic [KW-1:0] rx_blk, rx_end_blk, tx_head_blk;
  logic [PW-1:0] rx_port, tx_port;
  logic [BW-1:0] rx_bcnt, tx_head_bcnt;
  logic [NP-1:0] tx_pend;

  bufq_top #(.NUM_PORTS(NP), .NUM_BLOCKS(NB), .RING_DEPTH(D), .BCNT_W(BW)) u_bufq_top (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .rx_grant(rx_grant), .rx_blk(rx_blk),
    .no_buf(no_buf), .rx_end(rx_end), .rx_ok(rx_ok), .rx_port(rx_port), .rx_bcnt(rx_bcnt),
    .rx_end_blk(rx_end_blk), .tx_pend(tx_pend), .tx_port(tx_port),
    .tx_head_bcnt(tx_head_bcnt), .tx_head_blk(tx_head_blk), .tx_done(tx_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit busy [NB];
  int inflight [$];
  int q_blk  [NP][$];
  int q_bcnt [NP][$];

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lowest_free(bit rel [NB]);
    for (int i = 0; i < NB; i++) if (!busy[i] || rel[i]) return i;
    return -1;
  endfunction

  function automatic int exp_pend();
    int v = 0;
    for (int p = 0; p < NP; p++) if (q_blk[p].size() != 0) v |= (1 << p);
    return v;
  endfunction

  task automatic step(bit do_alloc, bit do_end, bit ok, int eport, int bcnt,
                      bit do_tx, int tport, string tag);
    bit rel [NB];
    int eblk, lf, exp_grant;
    bit store;
    @(negedge clk);
    check(tx_pend == NP'(exp_pend()), "R6 pending flags", int'(tx_pend), exp_pend());
    if (inflight.size() == 0) do_end = 0;
    eblk = do_end ? inflight[0] : 0;
    rx_start = do_alloc; rx_end = do_end; rx_ok = ok; rx_port = PW'(eport);
    rx_bcnt = BW'(bcnt); rx_end_blk = KW'(eblk); tx_done = do_tx; tx_port = PW'(tport);
    foreach (rel[i]) rel[i] = 0;
    store = do_end && ok && (q_blk[eport].size() < D);
    if (do_end && !store) rel[eblk] = 1;
    if (do_tx && q_blk[tport].size() != 0) rel[q_blk[tport][0]] = 1;
    lf = lowest_free(rel);
    exp_grant = (do_alloc && lf >= 0) ? 1 : 0;
    #1;
    check(rx_grant == exp_grant[0], {tag, " grant"}, int'(rx_grant), exp_grant);
    if (exp_grant != 0) check(int'(rx_blk) == lf, {tag, " block index"}, int'(rx_blk), lf);
    check(no_buf == (lf < 0), "R3 no_buf flag", int'(no_buf), int'(lf < 0));
    if (q_blk[tport].size() != 0) begin
      check(int'(tx_head_blk) == q_blk[tport][0], "R6 head block", int'(tx_head_blk), q_blk[tport][0]);
      check(int'(tx_head_bcnt) == q_bcnt[tport][0], "R6 head bcnt", int'(tx_head_bcnt), q_bcnt[tport][0]);
    end
    for (int i = 0; i < NB; i++) if (rel[i]) busy[i] = 0;
    if (exp_grant != 0) begin busy[lf] = 1; inflight.push_back(lf); end
    if (do_tx && q_blk[tport].size() != 0) begin
      void'(q_blk[tport].pop_front()); void'(q_bcnt[tport].pop_front());
    end
    if (do_end) void'(inflight.pop_front());
    if (store) begin q_blk[eport].push_back(eblk); q_bcnt[eport].push_back(bcnt); end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; rx_start = 0; rx_end = 0; rx_ok = 0; rx_port = '0; rx_bcnt = '0;
    rx_end_blk = '0; tx_done = 0; tx_port = '0;
    foreach (busy[i]) busy[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(tx_pend == '0, "R1 reset pending", int'(tx_pend), 0);
    check(no_buf == 1'b0, "R1 reset no_buf", int'(no_buf), 0);
    // R1/R2: first grant is block 0
    step(1, 0, 0, 0, 0, 0, 0, "R1 R2");
    // R8: error end frees block 0, reallocated next
    step(0, 1, 0, 1, 64, 0, 0, "R8");
    step(1, 0, 0, 0, 0, 0, 1, "R8 realloc");
    // R10: done on empty port 2 with allocation
    step(1, 0, 0, 0, 0, 1, 2, "R10");
    step(0, 1, 0, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, 0, 0, "R8");
    // R9: five packets to port 0, fifth dropped
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 5; k++) step(0, 1, 1, 0, 100 + k, 0, 0, "R5");
    step(1, 0, 0, 0, 0, 0, 0, "R9 dropped block reused");
    // R9 with same-cycle retire on the full port: still dropped
    step(1, 0, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 1, 0, 300, 1, 0, "R9 drop during retire");
    // R7: drain port 0
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 1, 0, "R7");
    for (int k = 0; k < 4; k++) step(0, 1, 1, 3, 200 + k, 1, 0, "R5");
    // R3: claim all blocks
    for (int k = 0; k < NB; k++) step(1, 0, 0, 0, 0, 0, 1, "R3 fill");
    step(1, 0, 0, 0, 0, 0, 1, "R3 stalled");
    // R4: retire head of port 3 while requesting
    step(1, 0, 0, 0, 0, 1, 3, "R4");
    while (inflight.size() != 0) step(0, 1, 0, 0, 0, 1, 3, "R8");
    // random mix
    for (int k = 0; k < 600; k++)
      step($urandom % 2, ($urandom % 3) != 0, ($urandom % 5) != 0, $urandom % NP,
           $urandom % (1 << BW), $urandom % 2, $urandom % NP, "R2 random");
    for (int k = 0; k < 40; k++) step(0, 1, 0, 0, 0, 1, k % NP, "R7 drain");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule